// File: doc/BRIEF.md
# Delta Timestamp Packet Generator

This block is a local time source for a trace stream. A free-running prescaler turns the core clock into a tick. The tick advances a count register that is 21 bits wide by default. A timestamp packet is emitted in two cases: when a requester pulses the request input, or when the count reaches its largest value. The packet carries the count held at that moment, and the count is cleared as it is taken. Each packet therefore reports the ticks that have passed since the previous packet, not an absolute time.

The packet leaves as a byte stream under a valid/ready handshake. It starts with a fixed header byte. The count follows in 7-bit groups, least significant group first, with bit 7 of each byte used as a continuation flag. Requests that arrive while a packet is still waiting to start are folded into that packet. Choosing this packet over other trace sources happens outside the block.

Top module: `delta_ts_gen`

## Requirements
- R1: After reset the output valid is low, and the first packet reports the ticks counted since reset, starting from zero.
- R2: The tick period is 1, 4, 16 or 64 clock cycles for a divider select of 0, 1, 2 or 3. The prescaler runs freely from reset, so a tick falls on every clock edge n after reset for which n is a multiple of the period.
- R3: The count saturates at its maximum value and does not wrap. Reaching the maximum raises a packet request by itself.
- R4: A packet reports the number of ticks since the previous capture, and the count is cleared when it is captured.
- R5: If a tick lands on the same edge as a capture, the count restarts at 1 rather than 0.
- R6: A packet is the byte 0xC0, then the count in 7-bit groups, least significant group first. Bit 7 is 1 on every group except the last. Leading all-zero groups are left out, so a count of zero is sent as the single byte 0x00.
- R7: Any number of requests made while a packet is pending or being sent produce exactly one further packet.
- R8: A byte moves only when valid and ready are both high. While valid is high and ready is low, the data holds steady.
- R9: When no packet is in flight, a request raised at one clock edge makes the header valid right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Prescaler select: 0 is /1, 1 is /4, 2 is /16, 3 is /64 |
| ts_req_i | input | 1 | Timestamp request pulse |
| pkt_data_o | output | 8 | Packet byte |
| pkt_valid_o | output | 1 | Packet byte valid |
| pkt_ready_i | input | 1 | Consumer ready for the byte |

## Verification
Every divider setting is run with request pulses at many spacings, some of them back to back. The expected delta is derived from the capture edge alone, as the count of multiples of the period between two captures. This separates a wrong tick phase from a lost same-edge tick and from a count that is not cleared. Ready is held high in some runs and toggled pseudo-randomly in others, which exposes bytes that move without a handshake. A long stall with requests arriving throughout must produce exactly two packets, the second at the saturated maximum. A free run with no requests must yield back-to-back maximum-value packets that use the full three-group encoding.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned PRE_W  = 6;
  localparam int unsigned GRP_W  = 7;
  localparam logic [7:0]  TS_HDR = 8'hC0;

  function automatic logic [PRE_W-1:0] div_limit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'd0:    lim = PRE_W'(0);
      2'd1:    lim = PRE_W'(3);
      2'd2:    lim = PRE_W'(15);
      default: lim = PRE_W'(63);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler
  import ts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = div_limit(div_sel_i);
  assign tick_o = (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             capture_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (capture_i)          cnt_q <= tick_i ? CNT_W'(1) : '0; // keep a coincident tick
    else if (tick_i && !sat_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ts_packer.sv
module ts_packer
  import ts_pkg::*;
#(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             busy_o,
  output logic [7:0]       data_o,
  input  logic             ready_i
);
  logic             busy_q;
  logic             hdr_q;
  logic [CNT_W-1:0] sh_q;
  logic             more;
  logic             xfer;

  assign more   = (sh_q >> GRP_W) != '0;
  assign xfer   = busy_q && ready_i;
  assign busy_o = busy_q;
  assign data_o = hdr_q ? TS_HDR : {more, sh_q[GRP_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hdr_q  <= 1'b0;
      sh_q   <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      hdr_q  <= 1'b1;
      sh_q   <= value_i;
    end else if (xfer) begin
      if (hdr_q)     hdr_q  <= 1'b0;
      else if (more) sh_q   <= sh_q >> GRP_W;
      else           busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/delta_ts_gen.sv
module delta_ts_gen #(
  parameter int unsigned CNT_W = 21
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       ts_req_i,
  output logic [7:0] pkt_data_o,
  output logic       pkt_valid_o,
  input  logic       pkt_ready_i
);
  logic             tick;
  logic             sat;
  logic             busy;
  logic             pend_q;
  logic             trig;
  logic             capture;
  logic [CNT_W-1:0] cnt_q;

  assign trig    = ts_req_i | sat | pend_q;
  assign capture = trig & ~busy;

  // requests during a pending or active packet fold into one flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= trig & ~capture;
  end

  ts_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_sel_i),
    .tick_o    (tick)
  );

  ts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .capture_i (capture),
    .cnt_o     (cnt_q),
    .sat_o     (sat)
  );

  ts_packer #(.CNT_W(CNT_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (capture),
    .value_i (cnt_q),
    .busy_o  (busy),
    .data_o  (pkt_data_o),
    .ready_i (pkt_ready_i)
  );

  assign pkt_valid_o = busy;
endmodule

// File: rtl/ts_gen_chk.sv
module ts_gen_chk #(
  parameter int unsigned CNT_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ts_req_i,
  input logic [7:0]       pkt_data_o,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q <= CNT_W'(1)));

  p_header_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_valid_o) |-> (pkt_data_o == 8'hC0));

  p_prompt_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_req_i && !pkt_valid_o) |=> (pkt_valid_o && pkt_data_o == 8'hC0));

  p_last_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && pkt_data_o != 8'hC0 && !pkt_data_o[7])
      |=> !pkt_valid_o);
endmodule

bind delta_ts_gen ts_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ts_req_i    (ts_req_i),
  .pkt_data_o  (pkt_data_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .cnt_q       (cnt_q)
);

// File: tb/sim_delta_ts_gen.sv
`timescale 1ns/1ps
module sim_delta_ts_gen;
  localparam int CW   = 15;
  localparam int MAXV = (1 << CW) - 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic       ts_req_i = 1'b0;
  logic [7:0] pkt_data_o;
  logic       pkt_valid_o;
  logic       pkt_ready_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  int edge_n = 0;
  int d_cur = 1;
  logic rnd_mode = 1'b0, ready_force = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  // monitor state
  logic vprev = 1'b0, in_pkt = 1'b0, stall_seen = 1'b0;
  logic [7:0] stall_data = '0;
  int prev_e = 1, exp_v = 0, exp_g = 0, got_v = 0, grp = 0, pkt_cnt = 0, last_v = 0;

  delta_ts_gen #(.CNT_W(CW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_sel_i(div_sel_i), .ts_req_i(ts_req_i),
    .pkt_data_o(pkt_data_o), .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) edge_n <= 0;
    else         edge_n <= edge_n + 1;
  end

  always @(posedge clk_i) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pkt_ready_i <= rnd_mode ? lfsr[3] : ready_force;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int groups(input int v);
    int g = 1;
    for (int t = v >> 7; t != 0; t = t >> 7) g++;
    return g;
  endfunction

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      vprev = 0; in_pkt = 0; prev_e = 1; pkt_cnt = 0; stall_seen = 0;
    end else begin
      if (stall_seen && pkt_valid_o)
        check(pkt_data_o == stall_data, "R8 stall hold", pkt_data_o, stall_data);
      stall_seen = pkt_valid_o && !pkt_ready_i;
      stall_data = pkt_data_o;
      if (pkt_valid_o && !vprev) begin
        // R2 R4 R5: ticks on edges m in [prev_e, edge_n) with m % d == 0
        exp_v = (edge_n - 1) / d_cur - (prev_e - 1) / d_cur;
        if (exp_v > MAXV) exp_v = MAXV;   // R3
        exp_g = groups(exp_v);
        prev_e = edge_n;
        in_pkt = 1; grp = -1; got_v = 0;
      end
      vprev = pkt_valid_o;
      if (pkt_valid_o && pkt_ready_i && in_pkt) begin
        if (grp < 0) begin
          check(pkt_data_o == 8'hC0, "R6 header", pkt_data_o, 8'hC0);
          grp = 0;
        end else begin
          got_v = got_v | (int'(pkt_data_o[6:0]) << (7 * grp));
          grp++;
          if (!pkt_data_o[7]) begin
            check(got_v == exp_v, "R4 delta value", got_v, exp_v);
            check(grp == exp_g, "R6 group count", grp, exp_g);
            last_v = got_v;
            pkt_cnt++;
            in_pkt = 0;
          end
        end
      end
    end
  end

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk_i);
    rst_ni = 0;
    div_sel_i = sel;
    d_cur = 1 << (2 * sel);
    repeat (3) @(negedge clk_i);
    check(pkt_valid_o == 1'b0, "R1 valid low in reset", pkt_valid_o, 0);
    rst_ni = 1;
  endtask

  task automatic pulse_req(input int len);
    @(posedge clk_i); #1 ts_req_i = 1;
    repeat (len) @(posedge clk_i);
    #1 ts_req_i = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R2 R4 R5 R6 R9: every divider, varied spacing, steady and random ready
    for (int sel = 0; sel < 4; sel++) begin
      rnd_mode = sel[0];
      ready_force = 1'b1;
      do_reset(sel[1:0]);
      pulse_req(1);                 // R1: early packet from a fresh count
      wait_cyc(8);
      for (int i = 0; i < 14; i++) begin
        wait_cyc(1 + (i * 137 + sel * 53) % 300);
        pulse_req(1 + (i % 3));     // R7: held requests merge
      end
      rnd_mode = 0;
      wait_cyc(60);
      check(pkt_cnt >= 10, "R4 packets seen", pkt_cnt, 10);
    end

    // R7 R3 R8: long stall with many requests, then release
    rnd_mode = 0; ready_force = 0;
    do_reset(2'd0);
    pulse_req(1);
    for (int i = 0; i < 340; i++) begin
      wait_cyc(99);
      pulse_req(1);
    end
    @(negedge clk_i);
    check(pkt_cnt == 0 && pkt_valid_o, "R8 no byte moves without ready", pkt_cnt, 0);
    @(posedge clk_i); #1 ready_force = 1;
    wait_cyc(100);
    check(pkt_cnt == 2, "R7 merged packets", pkt_cnt, 2);
    check(last_v == MAXV, "R3 saturated value", last_v, MAXV);

    // R3: free run, counter reaches max and requests by itself
    do_reset(2'd0);
    wait_cyc(2 * MAXV + 200);
    check(pkt_cnt == 2, "R3 auto packets", pkt_cnt, 2);
    check(last_v == MAXV, "R3 auto value", last_v, MAXV);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule